// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector

This block watches the clock and data lines of a two-wire serial bus from inside the system clock domain. It reports three bus conditions: the opening condition, the repeated opening condition and the closing condition. Each is reported as a one-clock pulse, and the block keeps a bus-busy flag between an opening and a closing condition. Each opening condition, repeated or not, also sends a one-clock reset pulse to the slave logic beside it, so that the slave is ready to take in an address byte.

The block has two interrupt pulses, one for opening conditions and one for closing conditions. Each interrupt has its own enable. When the mode input says the surrounding logic always interrupts on these events, both interrupts fire and the two enables have no effect.

A master-side check samples the data line when a request to drive an opening condition arrives. If the line is already low, the block flags a bus collision. Glitch filtering beyond plain synchronisation is left to other logic, and so are data shifting and address matching.

Top module: `i2c_cond_detect`

## Requirements
- R1: After reset, and with both lines held high, every pulse output and `busBusy` read 0.
- R2: While the bus is idle, a data-line fall with the clock line high gives one `startPulse` three clocks after the line change, and `busBusy` goes to 1 on the same edge.
- R3: While busy, a data-line rise with the clock line high gives one `stopPulse` and clears `busBusy`, but only if the clock line was low at least once since the last opening condition.
- R4: If the data line falls and then rises while the clock line stays high the whole time, only the opening condition is reported and `busBusy` stays 1.
- R5: While busy, a data-line fall with the clock line high, at a point where a closing condition would be legal, gives one `restartPulse`. `busBusy` stays 1, and a later closing condition again needs a clock-low period first.
- R6: `slaveReset` pulses for one clock with every `startPulse` and every `restartPulse`.
- R7: When `intAlwaysOn` is 0, `startIrq` pulses with opening and repeated opening conditions only if `startIntEn` is 1. Likewise `stopIrq` pulses with closing conditions only if `stopIntEn` is 1.
- R8: When `intAlwaysOn` is 1, both interrupts pulse with their events whatever the values of `startIntEn` and `stopIntEn`.
- R9: A `startReq` strobe seen while the synchronised data line is low gives one `busCollision` pulse one clock later. With the data line high, no collision is flagged.
- R10: At most one of `startPulse`, `restartPulse` and `stopPulse` is high in any cycle, and each lasts exactly one clock.
- R11: While the bus is idle, a data-line rise with the clock line high is ignored: no `stopPulse` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw bus clock line |
| sdaIn | input | 1 | Raw bus data line |
| startReq | input | 1 | One-clock request to drive an opening condition |
| startIntEn | input | 1 | Enable for the opening-condition interrupt |
| stopIntEn | input | 1 | Enable for the closing-condition interrupt |
| intAlwaysOn | input | 1 | Mode in which both interrupts are always on |
| startPulse | output | 1 | Opening condition seen on an idle bus |
| restartPulse | output | 1 | Repeated opening condition seen |
| stopPulse | output | 1 | Valid closing condition seen |
| slaveReset | output | 1 | Reset pulse to the slave logic |
| busBusy | output | 1 | Bus is between an opening and a closing condition |
| busCollision | output | 1 | Data line was low when an opening condition was requested |
| startIrq | output | 1 | Opening-condition interrupt pulse |
| stopIrq | output | 1 | Closing-condition interrupt pulse |

## Verification
The assertions check on every cycle the relations between outputs. The three condition pulses never overlap, and each lasts only one clock. Busy rises only together with an opening condition and falls only with a closing one. Interrupts, slave reset and collision pulses appear only with their causes. Only the bench's line sequences can show the timing rules that depend on history: a closing condition is refused until the clock line has gone low, a repeated opening condition re-arms that rule, and an idle data-line rise is ignored.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  // Line activity seen by the datapath, handed to the control
  typedef struct packed {
    logic sdaFall;   // data fell with clock high on both samples
    logic sdaRise;   // data rose with clock high on both samples
    logic sclLow;    // synchronised clock line is low
    logic sdaLow;    // synchronised data line is low
  } lineFlags_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic start;
    logic restart;
    logic stop;
    logic setArmed;
    logic collide;
    logic irqStart;
    logic irqStop;
  } condStrobe_t;

endpackage

// File: rtl/i2c_cond_datapath.sv
module i2c_cond_datapath
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  condStrobe_t strobe,
  output lineFlags_t  flags,
  output logic        busy,
  output logic        armed,
  output logic        startPulse,
  output logic        restartPulse,
  output logic        stopPulse,
  output logic        slaveReset,
  output logic        busCollision,
  output logic        startIrq,
  output logic        stopIrq
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclSync;
  logic [LAST:0] sdaSync;
  logic          sclPrev;
  logic          sdaPrev;
  logic          sclQ;
  logic          sdaQ;

  // Synchroniser chains; an idle bus rests high, so they reset to ones
  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= {sclSync[LAST-1:0], sclIn};
          sdaSync <= {sdaSync[LAST-1:0], sdaIn};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclSync <= '1;
          sdaSync <= '1;
        end else begin
          sclSync <= sclIn;
          sdaSync <= sdaIn;
        end
      end
    end
  endgenerate

  assign sclQ = sclSync[LAST];
  assign sdaQ = sdaSync[LAST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclQ;
      sdaPrev <= sdaQ;
    end
  end

  always_comb begin
    flags.sdaFall = sdaPrev & ~sdaQ & sclPrev & sclQ;
    flags.sdaRise = ~sdaPrev & sdaQ & sclPrev & sclQ;
    flags.sclLow  = ~sclQ;
    flags.sdaLow  = ~sdaQ;
  end

  // Bus state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (strobe.start)     busy <= 1'b1;
      else if (strobe.stop) busy <= 1'b0;

      if (strobe.start || strobe.restart || strobe.stop) armed <= 1'b0;
      else if (strobe.setArmed)                          armed <= 1'b1;
    end
  end

  // Registered event outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse   <= 1'b0;
      restartPulse <= 1'b0;
      stopPulse    <= 1'b0;
      slaveReset   <= 1'b0;
      busCollision <= 1'b0;
      startIrq     <= 1'b0;
      stopIrq      <= 1'b0;
    end else begin
      startPulse   <= strobe.start;
      restartPulse <= strobe.restart;
      stopPulse    <= strobe.stop;
      slaveReset   <= strobe.start | strobe.restart;
      busCollision <= strobe.collide;
      startIrq     <= strobe.irqStart;
      stopIrq      <= strobe.irqStop;
    end
  end

endmodule

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl
  import i2c_cond_pkg::*;
(
  input  lineFlags_t  flags,
  input  logic        busy,
  input  logic        armed,
  input  logic        startReq,
  input  logic        startIntEn,
  input  logic        stopIntEn,
  input  logic        intAlwaysOn,
  output condStrobe_t strobe
);

  logic startEv;
  logic restartEv;
  logic stopEv;

  always_comb begin
    startEv   = flags.sdaFall & ~busy;
    restartEv = flags.sdaFall & busy & armed;
    stopEv    = flags.sdaRise & busy & armed;

    strobe.start    = startEv;
    strobe.restart  = restartEv;
    strobe.stop     = stopEv;
    strobe.setArmed = busy & flags.sclLow;
    strobe.collide  = startReq & flags.sdaLow;
    strobe.irqStart = (startEv | restartEv) & (startIntEn | intAlwaysOn);
    strobe.irqStop  = stopEv & (stopIntEn | intAlwaysOn);
  end

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic startReq,
  input  logic startIntEn,
  input  logic stopIntEn,
  input  logic intAlwaysOn,
  output logic startPulse,
  output logic restartPulse,
  output logic stopPulse,
  output logic slaveReset,
  output logic busBusy,
  output logic busCollision,
  output logic startIrq,
  output logic stopIrq
);

  lineFlags_t  flags;
  condStrobe_t strobe;
  logic        armed;

  i2c_cond_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .sclIn        (sclIn),
    .sdaIn        (sdaIn),
    .strobe       (strobe),
    .flags        (flags),
    .busy         (busBusy),
    .armed        (armed),
    .startPulse   (startPulse),
    .restartPulse (restartPulse),
    .stopPulse    (stopPulse),
    .slaveReset   (slaveReset),
    .busCollision (busCollision),
    .startIrq     (startIrq),
    .stopIrq      (stopIrq)
  );

  i2c_cond_ctrl ctrl_i (
    .flags       (flags),
    .busy        (busBusy),
    .armed       (armed),
    .startReq    (startReq),
    .startIntEn  (startIntEn),
    .stopIntEn   (stopIntEn),
    .intAlwaysOn (intAlwaysOn),
    .strobe      (strobe)
  );

endmodule

// File: rtl/i2c_cond_detect_checker.sv
module i2c_cond_detect_checker (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic startIntEn,
  input logic stopIntEn,
  input logic intAlwaysOn,
  input logic startPulse,
  input logic restartPulse,
  input logic stopPulse,
  input logic slaveReset,
  input logic busBusy,
  input logic busCollision,
  input logic startIrq,
  input logic stopIrq
);

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startPulse, restartPulse, stopPulse}));                          // R10

  AST_START_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);                                               // R10

  AST_STOP_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |=> !stopPulse);                                                 // R10

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busBusy) |-> startPulse);                                            // R2

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> stopPulse);                                             // R3

  AST_STOP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> $past(busBusy) && !busBusy);                                 // R3

  AST_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    restartPulse |-> $past(busBusy) && busBusy);                               // R5

  AST_SLAVE_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse || restartPulse) |-> slaveReset);                              // R6

  AST_START_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    startIrq |-> (startPulse || restartPulse) && ($past(startIntEn) || $past(intAlwaysOn))); // R7

  AST_STOP_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    stopIrq |-> stopPulse && ($past(stopIntEn) || $past(intAlwaysOn)));        // R7

  AST_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse && $past(intAlwaysOn)) |-> stopIrq);                            // R8

  AST_COLLIDE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    busCollision |-> $past(startReq));                                         // R9

endmodule

bind i2c_cond_detect i2c_cond_detect_checker chk_i (.*);

// File: tb/i2c_cond_detect_tb_top.sv
module i2c_cond_detect_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic startReq = 1'b0;
  logic startIntEn = 1'b0;
  logic stopIntEn = 1'b0;
  logic intAlwaysOn = 1'b0;
  logic startPulse, restartPulse, stopPulse, slaveReset;
  logic busBusy, busCollision, startIrq, stopIrq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  int nStart, nRestart, nStop, nSlvRst, nColl, nIrqStart, nIrqStop;

  always #10 clk = ~clk;  // 50 MHz

  i2c_cond_detect dut_i (.*);

  // Pulse counters, sampled away from the active edge
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rstN) begin
      nStart    <= nStart + int'(startPulse);
      nRestart  <= nRestart + int'(restartPulse);
      nStop     <= nStop + int'(stopPulse);
      nSlvRst   <= nSlvRst + int'(slaveReset);
      nColl     <= nColl + int'(busCollision);
      nIrqStart <= nIrqStart + int'(startIrq);
      nIrqStop  <= nIrqStop + int'(stopIrq);
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearCounts();
    @(posedge clk);
    nStart = 0; nRestart = 0; nStop = 0; nSlvRst = 0;
    nColl = 0; nIrqStart = 0; nIrqStop = 0;
  endtask

  // Change the lines just after a falling edge, then let them settle
  task automatic setLines(input logic scl, input logic sda);
    @(negedge clk);
    #1;
    sclIn = scl;
    sdaIn = sda;
    repeat (6) @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    check("R1", "startPulse", int'(startPulse), 0);
    check("R1", "stopPulse", int'(stopPulse), 0);
    check("R1", "restartPulse", int'(restartPulse), 0);
    check("R1", "busBusy", int'(busBusy), 0);
    check("R1", "busCollision", int'(busCollision), 0);
  endtask

  task automatic testStartStop();
    startIntEn = 1'b1; stopIntEn = 1'b1; intAlwaysOn = 1'b0;
    clearCounts();
    setLines(1'b1, 1'b0);
    check("R2", "start count", nStart, 1);
    check("R2", "busy after start", int'(busBusy), 1);
    check("R6", "slave reset count", nSlvRst, 1);
    check("R7", "start irq enabled", nIrqStart, 1);
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R3", "stop count", nStop, 1);
    check("R3", "busy after stop", int'(busBusy), 0);
    check("R7", "stop irq enabled", nIrqStop, 1);
    check("R10", "no restart", nRestart, 0);
  endtask

  task automatic testNoLow();
    startIntEn = 1'b0; stopIntEn = 1'b0; intAlwaysOn = 1'b0;
    clearCounts();
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R4", "start count", nStart, 1);
    check("R4", "stop refused", nStop, 0);
    check("R4", "still busy", int'(busBusy), 1);
    setLines(1'b0, 1'b1);
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R3", "stop after low", nStop, 1);
    check("R7", "start irq masked", nIrqStart, 0);
    check("R7", "stop irq masked", nIrqStop, 0);
  endtask

  task automatic testRestart();
    startIntEn = 1'b1; stopIntEn = 1'b0; intAlwaysOn = 1'b0;
    clearCounts();
    setLines(1'b1, 1'b0);
    setLines(1'b0, 1'b0);
    setLines(1'b0, 1'b1);
    setLines(1'b1, 1'b1);
    setLines(1'b1, 1'b0);
    check("R5", "restart count", nRestart, 1);
    check("R5", "start count", nStart, 1);
    check("R5", "busy kept", int'(busBusy), 1);
    check("R6", "slave reset count", nSlvRst, 2);
    check("R7", "start irq on restart", nIrqStart, 2);
    setLines(1'b1, 1'b1);
    check("R5", "stop refused after restart", nStop, 0);
    setLines(1'b0, 1'b1);
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R5", "stop after low", nStop, 1);
    check("R7", "stop irq masked", nIrqStop, 0);
    check("R5", "idle at end", int'(busBusy), 0);
  endtask

  task automatic testAlwaysOn();
    startIntEn = 1'b0; stopIntEn = 1'b0; intAlwaysOn = 1'b1;
    clearCounts();
    setLines(1'b1, 1'b0);
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R8", "start irq forced", nIrqStart, 1);
    check("R8", "stop irq forced", nIrqStop, 1);
    intAlwaysOn = 1'b0;
  endtask

  task automatic testIdleRise();
    clearCounts();
    setLines(1'b0, 1'b1);
    setLines(1'b0, 1'b0);
    setLines(1'b1, 1'b0);
    setLines(1'b1, 1'b1);
    check("R11", "no stop while idle", nStop, 0);
    check("R11", "no start from low", nStart, 0);
    check("R11", "idle", int'(busBusy), 0);
  endtask

  task automatic pulseReq();
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic testCollision();
    clearCounts();
    setLines(1'b0, 1'b1);
    setLines(1'b0, 1'b0);
    pulseReq();
    check("R9", "collision with sda low", nColl, 1);
    setLines(1'b0, 1'b1);
    pulseReq();
    check("R9", "no collision with sda high", nColl, 1);
    setLines(1'b1, 1'b1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    testReset();
    testStartStop();
    testNoLow();
    testRestart();
    testAlwaysOn();
    testIdleRise();
    testCollision();
    finishRun();
  end

  initial begin
    wait (cycles > 20000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
    finishRun();
  end

endmodule